// File: doc/BRIEF.md
# Execute-Bundle Dispatcher for an Eight-Slot Wide-Issue Core

This block sits between instruction fetch and the functional units of a wide-issue core. It takes in one 256-bit fetch word, made of eight 32-bit operation segments, at a time. It cuts that word into issue bundles. A bundle is a run of consecutive segments joined by a chaining flag. The block sends every segment of a bundle, in the same cycle, to the functional-unit slot that the segment names. A fully chained fetch word goes out in a single cycle. A word with no chaining takes eight cycles, one segment per cycle.

The input side is a valid/ready stream. A fetch word is taken on a clock edge where `in_valid` and `in_ready` are both high. While the held word still has bundles left after the one issuing in the current cycle, `in_ready` stays low. Upstream must then keep `in_valid` and `in_packet` steady. The eight slot outputs carry no handshake: each slot shows a valid bit and an instruction word for one cycle. If two segments of one bundle name the same slot, a conflict pulse is raised and only the earlier segment is delivered.

Top module: `vd_dispatch`

## Requirements
- R1: While reset is applied and right after it, every slot valid bit is 0, `conflict` is 0 and `in_ready` is 1.
- R2: Bit 0 of each segment is its chain flag. A bundle starts at the first segment not yet issued and runs up to and including the first segment whose chain flag is 0.
- R3: Segment 7 (bits 255:224) always closes a bundle, even when its chain flag is 1.
- R4: Bits 3:1 of a segment give its target slot number, 0 to 7. The full 32-bit segment appears unchanged on `slot_word[s*32 +: 32]` of that slot.
- R5: Any slot that receives no segment in a cycle shows valid 0 and an all-zero word.
- R6: When several segments of one bundle name the same slot, the segment with the lowest index is delivered and the others are dropped. `conflict` is 1 in the same cycle the slot outputs show that bundle, and 0 otherwise.
- R7: Bundles go out one per cycle, in segment order. The outputs are registered: the first bundle of a fetch word accepted at edge k is visible after edge k+1.
- R8: `in_ready` is 1 when no fetch word is held, or when the held word's final bundle issues at the coming edge. Otherwise it is 0, and upstream must hold its stream steady.
- R9: A cycle in which no fetch word is held produces all slot valid bits 0 and `conflict` 0 after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word offered |
| in_ready | output | 1 | Dispatcher can take a fetch word at this edge |
| in_packet | input | 256 | Fetch word, segment i at bits i*32+31:i*32 |
| slot_valid | output | 8 | Per-slot issue valid |
| slot_word | output | 256 | Per-slot instruction word, slot s at bits s*32+31:s*32 |
| conflict | output | 1 | Two or more segments of the shown bundle named one slot |

## Verification
Four properties are checked on every cycle. A taken fetch word always produces a non-empty bundle two edges later. Idle cycles issue nothing. A conflict never shows all eight slots filled. `in_ready` is never low while the buffer is empty. The split into bundles, the slot each segment lands on, which colliding segment survives, and the early release of `in_ready` on the final bundle are shown only by the bench. It compares every cycle against its own model, using directed fully chained, fully split and colliding words plus random streams with gaps and stalls.

// File: rtl/vd_pkg.sv
package vd_pkg;
  // Segment field positions that the dispatcher decodes
  localparam int CHAIN_BIT = 0;
  localparam int UNIT_LSB  = 1;
  localparam int DEF_NSEG  = 8;
  localparam int DEF_SEGW  = 32;
  localparam int DEF_UNITW = 3;
endpackage

// File: rtl/vd_bundle_sel.sv
module vd_bundle_sel #(
  parameter int N_SEG = 8,
  parameter int PTR_W = 3
) (
  input  logic [N_SEG-1:0] chain,
  input  logic [PTR_W-1:0] start,
  output logic [N_SEG-1:0] member,
  output logic [PTR_W-1:0] next_start,
  output logic             final_b
);
  // Marks the segments of the bundle beginning at 'start'
  always_comb begin
    logic open_run;
    open_run   = 1'b1;
    member     = '0;
    final_b    = 1'b0;
    next_start = start;
    for (int i = 0; i < N_SEG; i++) begin
      if ((i >= int'(start)) && open_run) begin
        member[i] = 1'b1;
        if (!chain[i] || (i == N_SEG-1)) begin
          open_run   = 1'b0;
          final_b    = (i == N_SEG-1);
          next_start = PTR_W'(i + 1);
        end
      end
    end
  end
endmodule

// File: rtl/vd_slot_route.sv
module vd_slot_route #(
  parameter int N_SEG  = 8,
  parameter int SEG_W  = 32,
  parameter int UNIT_W = 3,
  parameter int N_SLOT = 8
) (
  input  logic [N_SEG*SEG_W-1:0]  segs,
  input  logic [N_SEG-1:0]        member,
  output logic [N_SLOT-1:0]       hit,
  output logic [N_SLOT*SEG_W-1:0] word,
  output logic                    clash
);
  import vd_pkg::*;
  logic [N_SLOT-1:0] multi;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic             h;
    logic             m;
    logic [SEG_W-1:0] w;
    // Lowest-index segment naming this slot wins
    always_comb begin
      h = 1'b0;
      m = 1'b0;
      w = '0;
      for (int i = 0; i < N_SEG; i++) begin
        if (member[i] && (segs[i*SEG_W+UNIT_LSB +: UNIT_W] == UNIT_W'(s))) begin
          if (!h) begin
            h = 1'b1;
            w = segs[i*SEG_W +: SEG_W];
          end else begin
            m = 1'b1;
          end
        end
      end
    end
    assign hit[s]                  = h;
    assign multi[s]                = m;
    assign word[s*SEG_W +: SEG_W]  = w;
  end

  assign clash = |multi;
endmodule

// File: rtl/vd_dispatch.sv
module vd_dispatch #(
  parameter int N_SEG  = vd_pkg::DEF_NSEG,
  parameter int SEG_W  = vd_pkg::DEF_SEGW,
  parameter int UNIT_W = vd_pkg::DEF_UNITW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [N_SEG*SEG_W-1:0]        in_packet,
  output logic [(1<<UNIT_W)-1:0]        slot_valid,
  output logic [(1<<UNIT_W)*SEG_W-1:0]  slot_word,
  output logic                          conflict
);
  import vd_pkg::*;
  localparam int N_SLOT = 1 << UNIT_W;
  localparam int PTR_W  = $clog2(N_SEG);
  localparam int PKT_W  = N_SEG * SEG_W;

  logic [PKT_W-1:0]        pkt_q;
  logic                    full_q;
  logic [PTR_W-1:0]        ptr_q;
  logic [N_SEG-1:0]        chain;
  logic [N_SEG-1:0]        member;
  logic [PTR_W-1:0]        next_ptr;
  logic                    final_b;
  logic [N_SLOT-1:0]       hit;
  logic [N_SLOT*SEG_W-1:0] word;
  logic                    clash;
  logic                    accept;

  for (genvar i = 0; i < N_SEG; i++) begin : g_chain
    assign chain[i] = pkt_q[i*SEG_W + CHAIN_BIT];
  end

  vd_bundle_sel #(.N_SEG(N_SEG), .PTR_W(PTR_W)) u_sel (
    .chain      (chain),
    .start      (ptr_q),
    .member     (member),
    .next_start (next_ptr),
    .final_b    (final_b)
  );

  vd_slot_route #(.N_SEG(N_SEG), .SEG_W(SEG_W), .UNIT_W(UNIT_W), .N_SLOT(N_SLOT)) u_route (
    .segs   (pkt_q),
    .member (member),
    .hit    (hit),
    .word   (word),
    .clash  (clash)
  );

  assign in_ready = !full_q || final_b;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q      <= '0;
      full_q     <= 1'b0;
      ptr_q      <= '0;
      slot_valid <= '0;
      slot_word  <= '0;
      conflict   <= 1'b0;
    end else begin
      slot_valid <= full_q ? hit  : '0;
      slot_word  <= full_q ? word : '0;
      conflict   <= full_q && clash;
      if (full_q) begin
        ptr_q <= next_ptr;
        if (final_b) full_q <= 1'b0;
      end
      if (accept) begin
        pkt_q  <= in_packet;
        full_q <= 1'b1;
        ptr_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/vd_checker.sv
module vd_checker #(
  parameter int N_SLOT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [N_SLOT-1:0] slot_valid,
  input logic              conflict,
  input logic              busy
);
  AST_BUNDLE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 (slot_valid != '0)); // R7
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((slot_valid == '0) && !conflict)); // R9
  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> ($countones(slot_valid) < N_SLOT)); // R6
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready); // R8
endmodule

bind vd_dispatch vd_checker #(.N_SLOT(N_SLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .slot_valid (slot_valid),
  .conflict   (conflict),
  .busy       (full_q)
);

// File: tb/sim_vd_dispatch.sv
module sim_vd_dispatch;
  localparam int NS = 8;
  localparam int SW = 32;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [NS*SW-1:0] in_packet = '0;
  logic [NL-1:0]    slot_valid;
  logic [NL*SW-1:0] slot_word;
  logic             conflict;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vd_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_packet(in_packet), .slot_valid(slot_valid), .slot_word(slot_word),
    .conflict(conflict)
  );

  // ---------------- reference model ----------------
  logic [NS*SW-1:0] m_pkt = '0;
  logic             m_full = 1'b0;
  int               m_ptr = 0;
  logic [NL-1:0]    e_v = '0;
  logic [NL*SW-1:0] e_w = '0;
  logic             e_c = 1'b0;

  // R2 R3: bundle is start .. first unchained segment, segment 7 always closes
  function automatic int bundle_end(input logic [NS*SW-1:0] p, input int st);
    for (int i = st; i < NS; i++)
      if (!p[i*SW] || i == NS-1) return i;
    return NS-1;
  endfunction

  function automatic logic model_ready();
    if (!m_full) return 1'b1;
    return bundle_end(m_pkt, m_ptr) == NS-1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_full = 1'b0; m_ptr = 0; e_v = '0; e_w = '0; e_c = 1'b0;
    end else begin
      logic rdy;
      rdy = model_ready();
      e_v = '0; e_w = '0; e_c = 1'b0;
      if (m_full) begin
        int last;
        last = bundle_end(m_pkt, m_ptr);
        for (int i = m_ptr; i <= last; i++) begin
          int u;
          u = int'(m_pkt[i*SW+1 +: 3]);          // R4 unit field
          if (!e_v[u]) begin
            e_v[u] = 1'b1;
            e_w[u*SW +: SW] = m_pkt[i*SW +: SW];
          end else begin
            e_c = 1'b1;                          // R6 later one dropped
          end
        end
        if (last == NS-1) m_full = 1'b0;
        m_ptr = last + 1;
      end
      if (in_valid && rdy) begin
        m_pkt = in_packet; m_full = 1'b1; m_ptr = 0;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (slot_valid !== e_v) begin
        errors++;
        $display("FAIL R2 R3 R5 R7 R9 slot_valid actual=%b expected=%b", slot_valid, e_v);
      end
      checks++;
      if (slot_word !== e_w) begin
        errors++;
        $display("FAIL R4 R5 slot_word actual=%h expected=%h", slot_word, e_w);
      end
      checks++;
      if (conflict !== e_c) begin
        errors++;
        $display("FAIL R6 conflict actual=%b expected=%b", conflict, e_c);
      end
      checks++;
      if (in_ready !== model_ready()) begin
        errors++;
        $display("FAIL R8 in_ready actual=%b expected=%b", in_ready, model_ready());
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [SW-1:0] mkseg(input int unit, input logic chain_f, input logic [27:0] body);
    return {body, unit[2:0], chain_f};
  endfunction

  // Offer a word and hold it steady until it is taken (R8 back-pressure)
  task automatic send(input logic [NS*SW-1:0] p, input int gap);
    logic rdy;
    in_valid  = 1'b1;
    in_packet = p;
    do begin
      rdy = in_ready;
      @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0;
    in_packet = {8{32'hDEAD_BEEF}};
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    logic [NS*SW-1:0] p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: state during reset
    checks++;
    if (slot_valid !== '0 || conflict !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%b/%b expected=0/0/1", slot_valid, conflict, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (slot_valid !== '0 || conflict !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset actual=%b/%b/%b expected=0/0/1", slot_valid, conflict, in_ready);
    end

    // R2 R3: all chained incl. segment 7 flag -> one bundle, every slot
    for (int i = 0; i < NS; i++) p[i*SW +: SW] = mkseg(i, 1'b1, 28'(i*16 + 1));
    send(p, 3);
    // R2 R7: no chaining -> eight single-segment bundles
    for (int i = 0; i < NS; i++) p[i*SW +: SW] = mkseg(7-i, 1'b0, 28'(i + 100));
    send(p, 0);
    // R6: segments 0,1 collide on slot 2, segment 2 on slot 5
    p = '0;
    p[0 +: SW]    = mkseg(2, 1'b1, 28'h0AAAAAA);
    p[SW +: SW]   = mkseg(2, 1'b1, 28'h0BBBBBB);
    p[2*SW +: SW] = mkseg(5, 1'b0, 28'h0CCCCCC);
    for (int i = 3; i < NS; i++) p[i*SW +: SW] = mkseg(i, 1'b0, 28'(i));
    send(p, 0);
    // R8: back-to-back words with no gap
    for (int i = 0; i < NS; i++) p[i*SW +: SW] = mkseg(i % 4, (i % 3) != 2, 28'(i * 7));
    send(p, 0);
    send(p, 2);

    // Random stream with gaps
    for (int k = 0; k < 600; k++) begin
      for (int i = 0; i < NS; i++) begin
        p[i*SW +: SW] = $urandom;
        p[i*SW] = ($urandom % 4) != 0;
      end
      send(p, ($urandom % 4 == 0) ? int'($urandom % 3) : 0);
    end
    repeat (12) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule